// File: doc/BRIEF.md
# Four-Instruction Single-Cycle Core

This block is a 32-bit processor that completes one instruction per clock: fetch, decode, register read, arithmetic, data access, write-back and next-PC selection all happen between two rising edges. It knows four operations: register-to-register add, word load, word store and branch-if-equal. Every other encoding leaves the machine state untouched apart from the program counter.

Program and data live in two internal word memories of 256 words each. Software preloads the program store before reset is released. The data store starts from a fixed computed pattern, so a program can load constants without an immediate-add operation. The next PC comes from two dedicated adders, one for the sequential address and one for the branch target. The ALU is used for address generation and for the equality compare of a branch. For observation, the core shows the PC of the instruction now executing and the register write that this instruction will commit at the next edge.

Top module: `quad_op_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, and no register or data-memory word is written; `dbg_wr_en` stays low while `rst` is high.
- R2: The instruction executed is program word PC[9:2]. When no branch is taken, the PC advances by 4 each cycle, and `dbg_pc` shows the PC of the executing instruction.
- R3: Opcode bits [31:26]=6'h00 with bits [10:6]=0 and function bits [5:0]=6'h20 write (rs+rt) mod 2^32 into rd. The field positions are rs=[25:21], rt=[20:16] and rd=[15:11].
- R4: Opcode 6'h23 writes data word ((rs + sign-extended [15:0])[9:2]) into rt.
- R5: Opcode 6'h2B stores rt into data word ((rs + sign-extended [15:0])[9:2]) and writes no register. A later load of that word returns the stored value.
- R6: Opcode 6'h04 sets the next PC to PC+4+(sign-extended [15:0] << 2) when rs equals rt, and to PC+4 otherwise. It writes no register.
- R7: Register 0 reads as zero. Writes to it are dropped and are not shown as a write on the debug port.
- R8: A register write lands at the edge that ends the instruction. The instruction that produced it reads the old value, and the next instruction reads the new one.
- R9: Any other encoding, including an R-type word with a nonzero [10:6] or a function code other than 6'h20, writes nothing and only advances the PC.
- R10: After power-up, data word i holds (i * 32'h9E3779B9) ^ 32'h5A5AA5A5, truncated to 32 bits.
- R11: `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_data` give, in the same cycle, the destination and value of the write that the executing instruction commits at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | PC of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register write is committed at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
A corrupted PC shows on `dbg_pc` in the very next cycle, and from then on the debug write stream no longer matches the expected program order. A wrong register value stays hidden until an add, load or store uses it. It then shows as wrong data on `dbg_wr_data`, or as a wrong branch decision that shows on `dbg_pc` one cycle later. A misplaced store is seen only when a later load reads that word back. For this reason the program stores words and then reloads them, and it loads from many addresses that were never stored, so that the initial data pattern is also checked.

// File: rtl/qcore_pkg.sv
package qcore_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/qcore_ctrl.sv
module qcore_ctrl
  import qcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{default: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OP_RTYPE: if (shamt == 5'd0 && funct == FN_ADD) begin
        ctl.reg_dst   = 1'b1;
        ctl.reg_write = 1'b1;
      end
      OP_LOAD: begin
        ctl.alu_src    = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_write  = 1'b1;
        ctl.mem_read   = 1'b1;
      end
      OP_STORE: begin
        ctl.alu_src   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

  // R9: at most one kind of state change per instruction
  always_comb begin
    a_r9_one_effect: assert ($onehot0({ctl.reg_write, ctl.mem_write, ctl.branch}));
  end
endmodule

// File: rtl/qcore_alu.sv
module qcore_alu
  import qcore_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    y    = (op == ALU_SUB) ? (a - b) : (a + b);
    zero = (y == '0);
  end
endmodule

// File: rtl/qcore_regfile.sv
module qcore_regfile #(
  parameter int W     = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [W-1:0]     wd,
  input  logic [IDX_W-1:0] ra1,
  input  logic [IDX_W-1:0] ra2,
  output logic [W-1:0]     rd1,
  output logic [W-1:0]     rd2
);
  localparam int NREG = 2 ** IDX_W;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/qcore_wordmem.sv
module qcore_wordmem #(
  parameter int           W         = 32,
  parameter int           WORDS     = 256,
  parameter bit           INIT_HASH = 1'b0,
  parameter logic [W-1:0] FILL      = '0,
  parameter logic [W-1:0] HASH_MUL  = 32'h9E3779B9,
  parameter logic [W-1:0] HASH_XOR  = 32'h5A5AA5A5,
  localparam int          AW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      if (INIT_HASH) mem[i] = (W'(i) * HASH_MUL) ^ HASH_XOR;
      else           mem[i] = FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/quad_op_core.sv
module quad_op_core
  import qcore_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_wr_en,
  output logic [4:0]      dbg_wr_idx,
  output logic [XLEN-1:0] dbg_wr_data
);
  localparam int IDX_W = 5;
  localparam int IAW   = $clog2(IMEM_WORDS);
  localparam int DAW   = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]  pc_q, pc_next, pc_plus4, br_target;
  logic [31:0]      instr;
  ctrl_t            ctl;
  logic [XLEN-1:0]  rs_val, rt_val, imm_sext, alu_b, alu_y, ld_data, wb_data;
  logic             alu_zero, take_br, rf_we, dm_we;
  logic [IDX_W-1:0] wr_idx;

  qcore_wordmem #(.W(32), .WORDS(IMEM_WORDS), .INIT_HASH(1'b0), .FILL(32'hFC00_0000)) u_imem (
    .clk(clk), .we(1'b0), .addr(pc_q[IAW+1:2]), .wdata(32'h0), .rdata(instr));

  qcore_ctrl u_ctrl (
    .opcode(instr[31:26]), .shamt(instr[10:6]), .funct(instr[5:0]), .ctl(ctl));

  assign wr_idx  = ctl.reg_dst ? instr[15:11] : instr[20:16];
  assign rf_we   = ctl.reg_write & ~rst;
  assign wb_data = ctl.mem_to_reg ? ld_data : alu_y;

  qcore_regfile #(.W(XLEN), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .we(rf_we), .wa(wr_idx), .wd(wb_data),
    .ra1(instr[25:21]), .ra2(instr[20:16]), .rd1(rs_val), .rd2(rt_val));

  assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b    = ctl.alu_src ? imm_sext : rt_val;

  qcore_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero));

  assign dm_we = ctl.mem_write & ~rst;

  qcore_wordmem #(.W(XLEN), .WORDS(DMEM_WORDS), .INIT_HASH(1'b1)) u_dmem (
    .clk(clk), .we(dm_we), .addr(alu_y[DAW+1:2]), .wdata(rt_val), .rdata(ld_data));

  // next-PC path: two adders of its own, independent of the ALU
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign take_br   = ctl.branch & alu_zero;
  assign pc_next   = take_br ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = rf_we & (wr_idx != '0);
  assign dbg_wr_idx  = wr_idx;
  assign dbg_wr_data = wb_data;

  // R1: reset forces the PC to zero
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc_q == '0));
  // R2: sequential flow when no branch is taken
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    !take_br |=> (pc_q == $past(pc_q) + XLEN'(4)));
  // R6: a taken branch lands on the target adder's result
  a_r6_branch_target: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc_q == $past(br_target)));
  // R3: a valid add with nonzero rd always commits
  a_r3_add_commits: assert property (@(posedge clk) disable iff (rst)
    (ctl.reg_dst && instr[15:11] != 5'd0) |-> (dbg_wr_en && dbg_wr_idx == instr[15:11]));
  // R4: a load targets the rt field
  a_r4_load_dest: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_read |-> (dbg_wr_idx == instr[20:16]));
  // R7: a write to register 0 is never reported
  a_r7_no_r0_write: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_en |-> (dbg_wr_idx != 5'd0));
endmodule

// File: tb/sim_quad_op_core.sv
`timescale 1ns/1ps
module sim_quad_op_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_idx;
  logic [31:0] dbg_wr_data;

  int errors = 0;
  int checks = 0;
  bit reported = 1'b0;

  logic [31:0] prog  [256];
  logic [31:0] mregs [32];
  logic [31:0] mram  [256];
  logic [31:0] mpc;

  always #2.5 clk = ~clk;

  quad_op_core u0 (.clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
                   .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data));

  function automatic logic [31:0] ram_init(int i);
    return (32'(i) * 32'h9E3779B9) ^ 32'h5A5AA5A5;
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at pc=%h", tag, act, exp, mpc);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one cycle of the reference model, compared with the debug port
  task automatic step_and_check();
    logic [31:0] ins, a, b, simm, ea, npc, data;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh, idx;
    logic        en;
    string       tag;
    ins  = prog[mpc[9:2]];
    op   = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh   = ins[10:6];  fn = ins[5:0];
    simm = {{16{ins[15]}}, ins[15:0]};
    a    = (rs == 0) ? 32'h0 : mregs[rs];
    b    = (rt == 0) ? 32'h0 : mregs[rt];
    npc  = mpc + 32'd4;
    en = 1'b0; idx = 5'd0; data = 32'h0; tag = "R9";
    ea = a + simm;
    case (op)
      6'h00: if (sh == 0 && fn == 6'h20) begin
        tag = (rd == 0) ? "R7" : "R3"; idx = rd; data = a + b; en = (rd != 0);
      end
      6'h23: begin
        tag = (rt == 0) ? "R7" : "R4/R10"; idx = rt; data = mram[ea[9:2]]; en = (rt != 0);
      end
      6'h2B: begin tag = "R5"; mram[ea[9:2]] = b; end
      6'h04: begin tag = "R6"; if (a == b) npc = mpc + 32'd4 + {simm[29:0], 2'b00}; end
      default: tag = "R9";
    endcase
    check("R2 pc", dbg_pc, mpc);
    check({tag, " R11 wr_en"}, 32'(dbg_wr_en), 32'(en));
    if (en) begin
      check({tag, " R11 wr_idx"}, 32'(dbg_wr_idx), 32'(idx));
      check({tag, " R8 wr_data"}, dbg_wr_data, data);
      mregs[idx] = data;
    end
    mpc = npc;
  endtask

  task automatic build_program();
    int w = 0;
    int k;
    int ra, rb, rc;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) prog[i] = 32'hFC00_0000;
    // R10: fill r1..r31 from the initial data pattern
    for (int i = 0; i < 31; i++) begin prog[w] = enc_i(6'h23, 0, i + 1, 16'(i * 4)); w++; end
    // R7: write to r0 dropped, r0 reads zero
    prog[w] = enc_r(1, 2, 0, 0, 6'h20); w++;
    prog[w] = enc_r(0, 0, 3, 0, 6'h20); w++;
    prog[w] = enc_i(6'h23, 0, 0, 16'd8); w++;
    // R9: malformed and unknown encodings
    prog[w] = enc_r(1, 2, 4, 3, 6'h20); w++;
    prog[w] = enc_r(1, 2, 4, 0, 6'h22); w++;
    prog[w] = 32'hFC22_1111; w++;
    // R8: self-referencing add uses the old value
    prog[w] = enc_r(5, 5, 5, 0, 6'h20); w++;
    prog[w] = enc_r(5, 1, 6, 0, 6'h20); w++;
    // R5: store then reload, also with a negative offset from a register base
    prog[w] = enc_i(6'h2B, 0, 5, 16'd160); w++;
    prog[w] = enc_i(6'h23, 0, 7, 16'd160); w++;
    prog[w] = enc_i(6'h2B, 9, 8, 16'hFFF0); w++;
    prog[w] = enc_i(6'h23, 9, 10, 16'hFFF0); w++;
    // R6: taken skip, not-taken compare
    prog[w] = enc_i(6'h04, 0, 0, 16'd1); w++;
    prog[w] = enc_r(1, 1, 11, 0, 6'h20); w++;
    prog[w] = enc_i(6'h04, 1, 2, 16'd1); w++;
    prog[w] = enc_r(2, 2, 12, 0, 6'h20); w++;
    // R6: forward, backward, forward hop
    k = w;
    prog[k]   = enc_i(6'h04, 0, 0, 16'd5);
    prog[k+1] = enc_r(1, 1, 13, 0, 6'h20);
    prog[k+2] = enc_r(1, 1, 13, 0, 6'h20);
    prog[k+3] = enc_i(6'h04, 0, 0, 16'd4);
    prog[k+4] = enc_r(1, 1, 13, 0, 6'h20);
    prog[k+5] = enc_r(1, 1, 13, 0, 6'h20);
    prog[k+6] = enc_i(6'h04, 0, 0, 16'hFFFC);
    prog[k+7] = enc_r(1, 1, 13, 0, 6'h20);
    w = k + 8;
    // random mix
    while (w < 237) begin
      k  = $urandom_range(0, 99);
      ra = $urandom_range(0, 31); rb = $urandom_range(0, 31); rc = $urandom_range(0, 31);
      if (k < 35)      prog[w] = enc_r(ra, rb, rc, 0, 6'h20);
      else if (k < 55) prog[w] = enc_i(6'h23, ra, rb, 16'($urandom));
      else if (k < 75) prog[w] = enc_i(6'h2B, ra, rb, 16'($urandom));
      else if (k < 92) prog[w] = enc_i(6'h04, ra, ($urandom_range(0, 2) == 0) ? ra : rb,
                                       16'($urandom_range(0, 3)));
      else             prog[w] = enc_r(ra, rb, rc, 0, 6'h21);
      w++;
    end
    prog[240] = enc_i(6'h04, 0, 0, 16'hFFFF);
  endtask

  initial begin
    build_program();
    for (int i = 0; i < 32; i++) mregs[i] = 32'h0;
    for (int i = 0; i < 256; i++) mram[i] = ram_init(i);
    #1;
    for (int i = 0; i < 256; i++) u0.u_imem.mem[i] = prog[i];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", dbg_pc, 32'h0);
    check("R1 no write in reset", 32'(dbg_wr_en), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R1 pc held", dbg_pc, 32'h0);
    rst = 1'b0;
    mpc = 32'h0;
    for (int c = 0; c < 600; c++) begin
      #1;
      step_and_check();
      @(negedge clk);
    end
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end
endmodule